// File: doc/BRIEF.md
# Extended Opcode Prefix Decoder

This block is the front end of an 8-bit instruction stream that has been widened with lane-width prefixes and two-byte register-triple instructions. Opcode bytes arrive one at a time on a valid/ready input. The block keeps track of a pending prefix and of the first half of a register-triple instruction. For every complete instruction it presents one descriptor on a valid/ready output. A descriptor holds the kind, the leading opcode, the lane width code, the register bank and, for the register-triple form, an operation field and three register indices. Prefix bytes that are misused or reserved raise a one-cycle `illegal` pulse. The block has no mode register: a prefix governs only the instruction that follows it.

Back-pressure works through a single output register. `in_ready` is high when that register is empty or is being drained in the same cycle (`out_ready` high). A byte is consumed on a clock edge where `in_valid` and `in_ready` are both high. A presented descriptor stays valid and unchanged until it is taken on an edge where `out_ready` is high. Prefix bytes and first halves also wait for `in_ready`, so no byte is ever dropped.

Top module: `xop_prefix_decoder`

## Requirements
- R1: After reset `out_valid` and `illegal` are 0 and `in_ready` is 1.
- R2: With no prefix pending, a byte whose low nibble is neither 7 nor F yields a legacy descriptor. In that descriptor `out_is_rr`=0, `out_opcode` is the byte, `out_width`=0 (8-bit lanes), `out_alt_bank`=0, and op/rd/ra/rb are all 0.
- R3: A byte 0xH7 with H in 0..3 is a prefix and produces no descriptor of its own. The next instruction carries `out_width`=H (0:8, 1:16, 2:32, 3:64 bits) and `out_alt_bank`=0.
- R4: A byte 0xH7 with H in 8..B gives the following instruction `out_width`=H-8 and `out_alt_bank`=1.
- R5: A byte 0xH7 with H in 4..7 or C..F is reserved. It raises `illegal` for one cycle, emits nothing and cancels any pending prefix. The next instruction decodes with width 0 and bank 0.
- R6: A byte with low nibble F is the first half of a register-triple instruction, and the next byte completes it. Take the 12-bit word W = {first[7:4], second[7:0]}. Then op=W[11:9], rd=W[8:6], ra=W[5:3] and rb=W[2:0]; `out_is_rr`=1 and `out_opcode` is the first byte.
- R7: When a valid prefix comes before a register-triple instruction, the width and bank of that prefix apply to it.
- R8: A prefix affects exactly one instruction. The instruction after that one decodes with width 0 and bank 0.
- R9: A valid prefix that arrives while another prefix is pending replaces it and raises exactly one `illegal` pulse.
- R10: The second byte of a register-triple instruction is never decoded as a prefix or as an opcode. For example, 0x07 in that position raises no `illegal` and only fills fields.
- R11: `in_ready` = !out_valid || out_ready. While `out_valid`=1 and `out_ready`=0, all descriptor outputs hold their values, and no descriptor is lost or duplicated.
- R12: A descriptor becomes valid in the cycle right after the edge that consumes its last byte. `illegal` is high in the cycle right after the edge that consumes the offending byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode byte present |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Fetched opcode byte |
| out_valid | output | 1 | Descriptor present |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_is_rr | output | 1 | 1 = register-triple form, 0 = legacy |
| out_opcode | output | 8 | Leading opcode byte |
| out_width | output | 2 | Lane width code (8 << code bits) |
| out_alt_bank | output | 1 | 1 = alternate register bank |
| out_op | output | 3 | Register-triple operation field |
| out_rd | output | 3 | Destination register index |
| out_ra | output | 3 | First source register index |
| out_rb | output | 3 | Second source register index |
| illegal | output | 1 | One-cycle pulse for a reserved or dropped prefix |

## Verification
A descriptor is due in the cycle after the edge that consumes its final byte, and an `illegal` pulse is due in the cycle after the edge that consumes the offending byte. The driver task knows which edge consumed each byte because it samples `in_ready` before that edge. At the falling edge that follows, it checks `out_valid` and `illegal` against what that byte should produce. A scoreboard queue holds the expected descriptors. A monitor takes them out on every falling edge where a handshake is pending, so results are compared in order, even while a pseudo-random `out_ready` pattern stalls the output and the monitor confirms that the outputs hold steady.

// File: rtl/xop_pkg.sv
package xop_pkg;
  parameter int OPC_W  = 8;
  parameter int NIB_W  = OPC_W / 2;
  parameter int WC_W   = 2;
  parameter int RIDX_W = 3;
  parameter int OPF_W  = 3;

  parameter logic [NIB_W-1:0] PFX_NIB = 4'h7;
  parameter logic [NIB_W-1:0] RR_NIB  = 4'hF;

  typedef struct packed {
    logic              is_rr;
    logic [OPC_W-1:0]  opcode;
    logic [WC_W-1:0]   wcode;
    logic              alt;
    logic [OPF_W-1:0]  op;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
  } xop_desc_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PFX  = 2'd1,
    S_RR2  = 2'd2
  } xop_state_e;
endpackage

// File: rtl/xop_byte_class.sv
module xop_byte_class
  import xop_pkg::*;
(
  input  logic [OPC_W-1:0] byte_i,
  output logic             is_pfx,
  output logic             pfx_rsvd,
  output logic             pfx_alt,
  output logic [WC_W-1:0]  pfx_wcode,
  output logic             is_rr
);
  // High nibble 0..3 selects primary bank, 8..B alternate; bit 6 set marks reserved.
  always_comb begin
    is_pfx    = (byte_i[NIB_W-1:0] == PFX_NIB);
    pfx_rsvd  = is_pfx && byte_i[OPC_W-2];
    pfx_alt   = byte_i[OPC_W-1];
    pfx_wcode = byte_i[NIB_W +: WC_W];
    is_rr     = (byte_i[NIB_W-1:0] == RR_NIB);
  end
endmodule

// File: rtl/xop_seq.sv
module xop_seq
  import xop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [OPC_W-1:0] byte_i,
  input  logic             is_pfx,
  input  logic             pfx_rsvd,
  input  logic             pfx_alt,
  input  logic [WC_W-1:0]  pfx_wcode,
  input  logic             is_rr,
  output logic             load,
  output xop_desc_t        desc,
  output logic             illegal
);
  xop_state_e       st;
  logic [WC_W-1:0]  pend_w;
  logic             pend_alt;
  logic [OPC_W-1:0] rr_b0;
  logic             ill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pend_w   <= '0;
      pend_alt <= 1'b0;
      rr_b0    <= '0;
      ill_q    <= 1'b0;
    end else begin
      ill_q <= 1'b0;
      if (take) begin
        if (st == S_RR2) begin
          st       <= S_IDLE;
          pend_w   <= '0;
          pend_alt <= 1'b0;
        end else if (is_pfx) begin
          if (pfx_rsvd) begin
            ill_q    <= 1'b1;
            st       <= S_IDLE;
            pend_w   <= '0;
            pend_alt <= 1'b0;
          end else begin
            ill_q    <= (st == S_PFX);
            st       <= S_PFX;
            pend_w   <= pfx_wcode;
            pend_alt <= pfx_alt;
          end
        end else if (is_rr) begin
          rr_b0 <= byte_i;
          st    <= S_RR2;
        end else begin
          st       <= S_IDLE;
          pend_w   <= '0;
          pend_alt <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    load = take && ((st == S_RR2) || (!is_pfx && !is_rr));
    desc = '0;
    desc.wcode = pend_w;
    desc.alt   = pend_alt;
    if (st == S_RR2) begin
      desc.is_rr  = 1'b1;
      desc.opcode = rr_b0;
      desc.op     = rr_b0[OPC_W-1 -: OPF_W];
      desc.rd     = {rr_b0[NIB_W], byte_i[OPC_W-1 -: RIDX_W-1]};
      desc.ra     = byte_i[RIDX_W +: RIDX_W];
      desc.rb     = byte_i[RIDX_W-1:0];
    end else begin
      desc.opcode = byte_i;
    end
  end

  assign illegal = ill_q;

  assert_ill_after_take_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !ill_q);
  assert_single_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (st == S_IDLE) && (pend_w == '0) && !pend_alt);
  assert_rr_second_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && st == S_RR2) |=> !ill_q);
endmodule

// File: rtl/xop_out_reg.sv
module xop_out_reg
  import xop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  xop_desc_t din,
  output logic      can_take,
  output logic      out_valid,
  input  logic      out_ready,
  output xop_desc_t dout
);
  logic      v_q;
  xop_desc_t d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else begin
      if (load) begin
        v_q <= 1'b1;
        d_q <= din;
      end else if (out_ready) begin
        v_q <= 1'b0;
      end
    end
  end

  assign can_take  = !v_q || out_ready;
  assign out_valid = v_q;
  assign dout      = d_q;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !out_ready) |=> v_q && $stable(d_q));
  assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!v_q || out_ready));
  assert_load_shows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> v_q);
endmodule

// File: rtl/xop_prefix_decoder.sv
module xop_prefix_decoder
  import xop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_rr,
  output logic [OPC_W-1:0]  out_opcode,
  output logic [WC_W-1:0]   out_width,
  output logic              out_alt_bank,
  output logic [OPF_W-1:0]  out_op,
  output logic [RIDX_W-1:0] out_rd,
  output logic [RIDX_W-1:0] out_ra,
  output logic [RIDX_W-1:0] out_rb,
  output logic              illegal
);
  logic            take, load, can_take;
  logic            is_pfx, pfx_rsvd, pfx_alt, is_rr;
  logic [WC_W-1:0] pfx_wcode;
  xop_desc_t       desc, dout;

  assign in_ready = can_take;
  assign take     = in_valid && can_take;

  xop_byte_class u_class (
    .byte_i(in_byte), .is_pfx(is_pfx), .pfx_rsvd(pfx_rsvd),
    .pfx_alt(pfx_alt), .pfx_wcode(pfx_wcode), .is_rr(is_rr)
  );

  xop_seq u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_i(in_byte),
    .is_pfx(is_pfx), .pfx_rsvd(pfx_rsvd), .pfx_alt(pfx_alt),
    .pfx_wcode(pfx_wcode), .is_rr(is_rr),
    .load(load), .desc(desc), .illegal(illegal)
  );

  xop_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .din(desc),
    .can_take(can_take), .out_valid(out_valid), .out_ready(out_ready),
    .dout(dout)
  );

  assign out_is_rr    = dout.is_rr;
  assign out_opcode   = dout.opcode;
  assign out_width    = dout.wcode;
  assign out_alt_bank = dout.alt;
  assign out_op       = dout.op;
  assign out_rd       = dout.rd;
  assign out_ra       = dout.ra;
  assign out_rb       = dout.rb;

  assert_no_prefix_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_opcode[NIB_W-1:0] != PFX_NIB));
  assert_rr_opcode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_rr) |-> (out_opcode[NIB_W-1:0] == RR_NIB));
  assert_legacy_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_rr) |-> (out_op == '0 && out_rd == '0 && out_ra == '0 && out_rb == '0));
endmodule

// File: tb/tb_xop_prefix_decoder.sv
`timescale 1ns/1ps
module tb_xop_prefix_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_byte = 8'h00;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_is_rr, out_alt_bank, illegal;
  logic [7:0] out_opcode;
  logic [1:0] out_width;
  logic [2:0] out_op, out_rd, out_ra, out_rb;

  always #2 clk = ~clk;

  xop_prefix_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_is_rr(out_is_rr), .out_opcode(out_opcode), .out_width(out_width),
    .out_alt_bank(out_alt_bank), .out_op(out_op), .out_rd(out_rd),
    .out_ra(out_ra), .out_rb(out_rb), .illegal(illegal)
  );

  int checks = 0;
  int fails = 0;
  int ill_seen = 0;
  int ill_exp = 0;
  bit rnd_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [23:0] sb[$];

  function automatic logic [23:0] cur_out();
    return {out_is_rr, out_opcode, out_width, out_alt_bank, out_op, out_rd, out_ra, out_rb};
  endfunction

  function automatic logic [23:0] mk_leg(logic [7:0] opc, logic [1:0] w, logic alt);
    return {1'b0, opc, w, alt, 12'h000};
  endfunction

  // R6: W = {b0[7:4], b1}; fields op, rd, ra, rb from W high to low.
  function automatic logic [23:0] mk_rr(logic [7:0] b0, logic [7:0] b1, logic [1:0] w, logic alt);
    logic [11:0] wd;
    wd = {b0[7:4], b1};
    return {1'b1, b0, w, alt, wd[11:9], wd[8:6], wd[5:3], wd[2:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic send(logic [7:0] b, bit exp_ill, bit exp_out, string req);
    bit acc;
    in_valid = 1'b1;
    in_byte  = b;
    acc = 1'b0;
    while (!acc) begin
      #1 acc = in_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (exp_ill) ill_exp++;
    chk(illegal == exp_ill, {req, " illegal timing R12"}, illegal, exp_ill);
    chk(out_valid == exp_out, {req, " out_valid timing R12"}, out_valid, exp_out);
  endtask

  // Ready pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= rnd_en ? lfsr[0] : 1'b1;
  end

  // Monitor / scoreboard
  logic [23:0] held;
  bit stalled = 1'b0;
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (illegal) ill_seen++;
      if (stalled) chk(out_valid && cur_out() == held, "R11 hold while stalled", cur_out(), held);
      stalled = out_valid && !out_ready;
      held = cur_out();
      chk(in_ready == (!out_valid || out_ready), "R11 in_ready rule", in_ready, !out_valid || out_ready);
      if (out_valid && out_ready) begin
        if (sb.size() == 0) chk(1'b0, "R11 unexpected descriptor", cur_out(), 0);
        else begin
          logic [23:0] e;
          e = sb.pop_front();
          chk(cur_out() == e, "R2/R3/R4/R6/R7 descriptor", cur_out(), e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(illegal == 1'b0, "R1 illegal", illegal, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 legacy pass-through
    sb.push_back(mk_leg(8'hA9, 2'd0, 1'b0)); send(8'hA9, 0, 1, "R2");
    sb.push_back(mk_leg(8'h00, 2'd0, 1'b0)); send(8'h00, 0, 1, "R2");
    // R3 / R4 every valid prefix code, then R8 default afterwards
    for (int h = 0; h < 12; h++) begin
      if (h < 4 || h >= 8) begin
        logic [7:0] p;
        p = {4'(h), 4'h7};
        send(p, 0, 0, h < 8 ? "R3" : "R4");
        sb.push_back(mk_leg(8'h69, 2'(h), h >= 8)); send(8'h69, 0, 1, h < 8 ? "R3" : "R4");
        sb.push_back(mk_leg(8'h65, 2'd0, 1'b0)); send(8'h65, 0, 1, "R8");
      end
    end
    // R5 reserved prefixes, alone and after a valid prefix
    send(8'h47, 1, 0, "R5");
    sb.push_back(mk_leg(8'h8D, 2'd0, 1'b0)); send(8'h8D, 0, 1, "R5");
    send(8'hB7, 0, 0, "R5");
    send(8'hC7, 1, 0, "R5");
    sb.push_back(mk_leg(8'h8D, 2'd0, 1'b0)); send(8'h8D, 0, 1, "R5");
    send(8'hF7, 1, 0, "R5");
    // R6 register-triple
    send(8'h3F, 0, 0, "R6");
    sb.push_back(mk_rr(8'h3F, 8'hD1, 2'd0, 1'b0)); send(8'hD1, 0, 1, "R6");
    // R7 prefix applies to register-triple, R8 then default
    send(8'hB7, 0, 0, "R7");
    send(8'hAF, 0, 0, "R7");
    sb.push_back(mk_rr(8'hAF, 8'h5A, 2'd3, 1'b1)); send(8'h5A, 0, 1, "R7");
    sb.push_back(mk_leg(8'hEA, 2'd0, 1'b0)); send(8'hEA, 0, 1, "R8");
    // R9 prefix replaces prefix
    send(8'h07, 0, 0, "R9");
    send(8'h17, 1, 0, "R9");
    sb.push_back(mk_leg(8'h18, 2'd1, 1'b0)); send(8'h18, 0, 1, "R9");
    // R10 second byte 0x07 and 0xC7 are plain fields
    send(8'h0F, 0, 0, "R10");
    sb.push_back(mk_rr(8'h0F, 8'h07, 2'd0, 1'b0)); send(8'h07, 0, 1, "R10");
    send(8'h97, 0, 0, "R10");
    send(8'hFF, 0, 0, "R10");
    sb.push_back(mk_rr(8'hFF, 8'hC7, 2'd1, 1'b1)); send(8'hC7, 0, 1, "R10");

    // R11 back-pressure with mixed stream
    rnd_en = 1'b1;
    for (int i = 0; i < 36; i++) begin
      int sel;
      logic [3:0] hi;
      logic [1:0] w;
      logic alt;
      sel = i % 9;
      hi = (sel < 4) ? 4'(sel) : 4'(sel + 4);
      w = 2'd0; alt = 1'b0;
      if (sel != 8) begin
        send({hi, 4'h7}, 0, 0, "R11");
        w = hi[1:0]; alt = hi[3];
      end
      if (i % 2 == 1) begin
        logic [7:0] b0, b1;
        b0 = {4'(i * 3), 4'hF};
        b1 = 8'(i * 37 + 5);
        send(b0, 0, 0, "R11");
        sb.push_back(mk_rr(b0, b1, w, alt)); send(b1, 0, 1, "R11");
      end else begin
        logic [7:0] opc;
        opc = {4'(i), 4'hA};
        sb.push_back(mk_leg(opc, w, alt)); send(opc, 0, 1, "R11");
      end
    end
    rnd_en = 1'b0;
    repeat (6) @(negedge clk);
    chk(sb.size() == 0, "R11 all descriptors delivered", sb.size(), 0);
    chk(ill_seen == ill_exp, "R5/R9 illegal pulse count", ill_seen, ill_exp);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule